// File: doc/BRIEF.md
# Sixteen-bit serial bus controller

This block links an 8-bit host bus to a synchronous serial line. The host stores a 16-bit word as two bytes in a pair of transmit registers. Storing the low byte arms the block. When the host's select line next goes high, a 16-bit exchange runs. During the exchange the block drives a shift clock and serial data, and holds an active-low enable strobe low. On the same clock it gathers 16 bits from the serial input. The host reads those bits back afterwards as two bytes.

The shift clock is the system clock divided by `DIV`, and it rests high when no exchange is running. Each bit occupies one full shift-clock period. The outgoing bits change on falling shift-clock edges, and the incoming bits are taken on rising edges. A control/status register holds the interrupt enable and shows the busy and interrupt-pending bits. Reading that register acknowledges the interrupt.

Top module: `sbc16_bridge`

## Requirements
- R1: After synchronous reset: `ser_clk`, `ser_out` and `ser_oe_n` are 1, and `irq` is 0. Both receive bytes read 0x00. The status register reads 0x00.
- R2: A host access is any cycle in which `hsel_n`=0. It is a write when `hwr_n`=0 and a read when `hrd_n`=0. `haddr` selects the register: 00 is the low transmit/receive byte and 01 is the high byte. 10 is control/status, with bit 0 the interrupt enable (read/write), bit 1 busy and bit 2 interrupt pending. Address 11 reads 0x00. Read data appears on `hrdata` one clock after the read cycle.
- R3: The word goes out high byte first and then low byte, each byte most significant bit first. `ser_out` is the same at each rising edge of `ser_clk` as in the cycle before it.
- R4: An exchange starts only on a rising edge of `hsel_n` that follows a write to address 00. Edges of `hsel_n` with no such write start nothing.
- R5: A read access made after the low-byte write, while `hsel_n` is still 0, cancels the pending start.
- R6: At the start, `ser_oe_n` drops to 0 one clock after `hsel_n` rises. `ser_clk` then makes exactly 16 rising edges spaced `DIV` clocks apart, and it is low only while `ser_oe_n` is 0.
- R7: `ser_in` is sampled on each rising edge of `ser_clk`. The first bit taken ends up in bit 15 of the received word.
- R8: `ser_oe_n` and `ser_out` return to 1, and busy clears, exactly `DIV` clocks after the 16th rising edge of `ser_clk`. While `ser_oe_n` is 1, `ser_out` is 1.
- R9: When an exchange ends with the interrupt enabled, `irq` rises in the same cycle as `ser_oe_n`. When the interrupt is disabled, `irq` stays 0. Reading the status register clears `irq`.
- R10: While busy, writes to addresses 00 and 01 are ignored: they change neither the bits being sent nor the armed state. Rising edges of `hsel_n` while busy do not restart the exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| hsel_n | input | 1 | Host select, active low; its rising edge fires an armed exchange |
| hrd_n | input | 1 | Host read strobe, active low |
| hwr_n | input | 1 | Host write strobe, active low |
| haddr | input | 2 | Register select |
| hwdata | input | DW | Host write data |
| hrdata | output | DW | Registered host read data |
| ser_clk | output | 1 | Generated shift clock, idles high |
| ser_out | output | 1 | Serial data out |
| ser_in | input | 1 | Serial data in |
| ser_oe_n | output | 1 | Active-low strobe, low for the whole exchange |
| irq | output | 1 | Interrupt request, active high |

## Verification
The properties assume that the host strobes are synchronous to `clk` and are sampled as plain levels. They also assume that `ser_in` changes only while `ser_clk` is steady. The bench drives every host input on the falling system edge. It changes `ser_in` only after it has seen a shift-clock rise, so the next sample comes at least half a shift period later. Host accesses made during an exchange are single-cycle writes, which exercise the busy rules without breaking these assumptions.

// File: rtl/sbc16_pkg.sv
package sbc16_pkg;
  localparam logic [1:0] ADDR_LO  = 2'b00;
  localparam logic [1:0] ADDR_HI  = 2'b01;
  localparam logic [1:0] ADDR_CTL = 2'b10;

  localparam int ST_IEN  = 0;
  localparam int ST_BUSY = 1;
  localparam int ST_PEND = 2;

  typedef enum logic [1:0] {
    XS_IDLE  = 2'd0,
    XS_SHIFT = 2'd1,
    XS_TAIL  = 2'd2
  } xfer_state_t;
endpackage

// File: rtl/sbc16_sckgen.sv
module sbc16_sckgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic fall_ev,
  output logic rise_ev
);
  localparam int HALF = DIV / 2;
  localparam int PW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [PW-1:0] ph;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      ph <= '0;
    end else if (ph == PW'(DIV - 1)) begin
      ph <= '0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign fall_ev = run && (ph == '0);
  assign rise_ev = run && (ph == PW'(HALF));
endmodule

// File: rtl/sbc16_hostif.sv
module sbc16_hostif
  import sbc16_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hsel_n,
  input  logic          hrd_n,
  input  logic          hwr_n,
  input  logic [1:0]    haddr,
  input  logic          ctl_bit,
  output logic [DW-1:0] hrdata,
  input  logic          busy,
  input  logic          done,
  input  logic [2*DW-1:0] rx_word,
  output logic          start,
  output logic          tx_lo_we,
  output logic          tx_hi_we,
  output logic          irq
);
  logic sel_q, armed, ien, pend;
  logic wr_acc, rd_acc, sel_rise;
  logic [DW-1:0] status;

  assign wr_acc   = !hsel_n && !hwr_n;
  assign rd_acc   = !hsel_n && !hrd_n;
  assign sel_rise = hsel_n && !sel_q;
  assign start    = sel_rise && armed && !busy;
  assign tx_lo_we = wr_acc && (haddr == ADDR_LO) && !busy;
  assign tx_hi_we = wr_acc && (haddr == ADDR_HI) && !busy;

  always_comb begin
    status = '0;
    status[ST_IEN]  = ien;
    status[ST_BUSY] = busy;
    status[ST_PEND] = pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q  <= 1'b1;
      armed  <= 1'b0;
      ien    <= 1'b0;
      pend   <= 1'b0;
      hrdata <= '0;
    end else begin
      sel_q <= hsel_n;
      if (start)         armed <= 1'b0;
      else if (tx_lo_we) armed <= 1'b1;
      else if (rd_acc)   armed <= 1'b0;
      if (wr_acc && haddr == ADDR_CTL) ien <= ctl_bit;
      if (done && ien)                          pend <= 1'b1;
      else if (rd_acc && haddr == ADDR_CTL)     pend <= 1'b0;
      if (rd_acc) begin
        case (haddr)
          ADDR_LO:  hrdata <= rx_word[DW-1:0];
          ADDR_HI:  hrdata <= rx_word[2*DW-1:DW];
          ADDR_CTL: hrdata <= status;
          default:  hrdata <= '0;
        endcase
      end
    end
  end

  assign irq = pend;
endmodule

// File: rtl/sbc16_shifter.sv
module sbc16_shifter
  import sbc16_pkg::*;
#(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic            tx_lo_we,
  input  logic            tx_hi_we,
  input  logic [DW-1:0]   wdata,
  input  logic            fall_ev,
  input  logic            rise_ev,
  input  logic            sdi,
  output logic            run,
  output logic            busy,
  output logic            done,
  output logic            sck,
  output logic            sdo,
  output logic            oe_n,
  output logic [2*DW-1:0] rx
);
  localparam int W  = 2 * DW;
  localparam int BW = $clog2(W);
  localparam int PW = (DIV > 2) ? $clog2(DIV) : 1;

  xfer_state_t   st;
  logic [W-1:0]  txs;
  logic [BW-1:0] bitc;
  logic [PW-1:0] tcnt;

  assign run  = (st == XS_SHIFT);
  assign done = (st == XS_TAIL) && (tcnt == PW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= XS_IDLE;
      busy <= 1'b0;
      sck  <= 1'b1;
      sdo  <= 1'b1;
      oe_n <= 1'b1;
      bitc <= '0;
      tcnt <= '0;
      rx   <= '0;
      txs  <= '0;
    end else begin
      if (tx_hi_we) txs[W-1:DW] <= wdata;
      if (tx_lo_we) txs[DW-1:0] <= wdata;
      case (st)
        XS_IDLE: begin
          if (start) begin
            st   <= XS_SHIFT;
            busy <= 1'b1;
            oe_n <= 1'b0;
            sdo  <= txs[W-1];
            bitc <= '0;
          end
        end
        XS_SHIFT: begin
          if (fall_ev) begin
            sck <= 1'b0;
            if (bitc != '0) begin
              sdo <= txs[W-2];
              txs <= {txs[W-2:0], 1'b0};
            end
          end
          if (rise_ev) begin
            sck <= 1'b1;
            rx  <= {rx[W-2:0], sdi};
            if (bitc == BW'(W - 1)) begin
              st   <= XS_TAIL;
              tcnt <= '0;
            end else begin
              bitc <= bitc + 1'b1;
            end
          end
        end
        XS_TAIL: begin
          if (done) begin
            st   <= XS_IDLE;
            busy <= 1'b0;
            oe_n <= 1'b1;
            sdo  <= 1'b1;
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        default: st <= XS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sbc16_bridge.sv
module sbc16_bridge #(
  parameter int DW  = 8,
  parameter int DIV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hsel_n,
  input  logic          hrd_n,
  input  logic          hwr_n,
  input  logic [1:0]    haddr,
  input  logic [DW-1:0] hwdata,
  output logic [DW-1:0] hrdata,
  output logic          ser_clk,
  output logic          ser_out,
  input  logic          ser_in,
  output logic          ser_oe_n,
  output logic          irq
);
  localparam int W = 2 * DW;

  logic start, tx_lo_we, tx_hi_we;
  logic run, busy, done, fall_ev, rise_ev;
  logic [W-1:0] rx_word;

  sbc16_hostif #(.DW(DW)) u_host (
    .clk(clk), .rst(rst), .hsel_n(hsel_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
    .haddr(haddr), .ctl_bit(hwdata[0]), .hrdata(hrdata), .busy(busy),
    .done(done), .rx_word(rx_word), .start(start), .tx_lo_we(tx_lo_we),
    .tx_hi_we(tx_hi_we), .irq(irq)
  );

  sbc16_sckgen #(.DIV(DIV)) u_sck (
    .clk(clk), .rst(rst), .run(run), .fall_ev(fall_ev), .rise_ev(rise_ev)
  );

  sbc16_shifter #(.DW(DW), .DIV(DIV)) u_shift (
    .clk(clk), .rst(rst), .start(start), .tx_lo_we(tx_lo_we),
    .tx_hi_we(tx_hi_we), .wdata(hwdata), .fall_ev(fall_ev),
    .rise_ev(rise_ev), .sdi(ser_in), .run(run), .busy(busy), .done(done),
    .sck(ser_clk), .sdo(ser_out), .oe_n(ser_oe_n), .rx(rx_word)
  );
endmodule

// File: rtl/sbc16_bridge_chk.sv
module sbc16_bridge_chk (
  input logic clk,
  input logic rst,
  input logic hsel_n,
  input logic ser_clk,
  input logic ser_out,
  input logic ser_oe_n,
  input logic irq
);
  AST_SDO_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(ser_clk) |-> $stable(ser_out)); // R3

  AST_START_ON_SEL_RISE: assert property (@(posedge clk) disable iff (rst)
    $fell(ser_oe_n) |-> ($past(hsel_n) && !$past(hsel_n, 2))); // R4

  AST_SCK_LOW_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    !ser_clk |-> !ser_oe_n); // R6

  AST_IDLE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    ser_oe_n |-> ser_out); // R8

  AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $rose(ser_oe_n)); // R9
endmodule

bind sbc16_bridge sbc16_bridge_chk u_chk (
  .clk(clk), .rst(rst), .hsel_n(hsel_n), .ser_clk(ser_clk),
  .ser_out(ser_out), .ser_oe_n(ser_oe_n), .irq(irq)
);

// File: tb/sim_sbc16_bridge.sv
module sim_sbc16_bridge;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int DW = 8;
  localparam int NV = 4;
  localparam logic [31:0] VEC [NV] = '{32'hA53C_F00F, 32'h0001_8000,
                                       32'hFFFF_0000, 32'h1234_ABCD};

  logic clk = 1'b0, rst = 1'b1;
  logic hsel_n = 1'b1, hrd_n = 1'b1, hwr_n = 1'b1;
  logic [1:0] haddr = 2'b00;
  logic [DW-1:0] hwdata = '0;
  logic [DW-1:0] hrdata;
  logic ser_clk, ser_out, ser_oe_n, irq;
  logic ser_in = 1'b1;
  int nchk = 0, nerr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbc16_bridge #(.DW(DW), .DIV(DIV)) u0 (
    .clk(clk), .rst(rst), .hsel_n(hsel_n), .hrd_n(hrd_n), .hwr_n(hwr_n),
    .haddr(haddr), .hwdata(hwdata), .hrdata(hrdata), .ser_clk(ser_clk),
    .ser_out(ser_out), .ser_in(ser_in), .ser_oe_n(ser_oe_n), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); hsel_n = 1'b0; hwr_n = 1'b0; haddr = a; hwdata = d;
    @(negedge clk); hwr_n = 1'b1; hsel_n = 1'b1;
  endtask

  task automatic host_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); hsel_n = 1'b0; hrd_n = 1'b0; haddr = a;
    @(negedge clk); d = hrdata; hrd_n = 1'b1; hsel_n = 1'b1;
  endtask

  task automatic idle_check(input string req);
    bit stayed = 1'b1;
    for (int n = 0; n < 4*DIV; n++) begin
      @(negedge clk);
      if (!ser_oe_n) stayed = 1'b0;
    end
    chk(stayed, req, 0, 1);
  endtask

  task automatic run_xfer(input logic [15:0] rxw, input bit inject,
                          output logic [15:0] got, output int rises,
                          output int badper, output int tail, output bit started);
    int since = 0, guard = 0, inj = 0;
    bit prev;
    rises = 0; badper = 0; tail = -1; got = '0;
    @(negedge clk);
    started = !ser_oe_n && ser_clk;
    prev = ser_clk;
    while (guard < 64*DIV) begin
      @(negedge clk);
      guard++; since++;
      if (inj == 1) begin hwr_n = 1'b1; hsel_n = 1'b1; inj = 2; end
      if (ser_clk && !prev) begin
        rises++;
        got = {got[14:0], ser_out};
        if (rises > 1 && since != DIV) badper++;
        since = 0;
        if (rises < 16) ser_in = rxw[15-rises];
        if (rises == 16) tail = 0;
        if (inject && rises == 4 && inj == 0) begin
          hsel_n = 1'b0; hwr_n = 1'b0; haddr = 2'b00; hwdata = 8'h5A; inj = 1;
        end
      end else if (tail >= 0) begin
        tail++;
      end
      prev = ser_clk;
      if (ser_oe_n) break;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    logic [7:0] rd;
    logic [15:0] got;
    int rises, badper, tail;
    bit started;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(ser_clk && ser_out && ser_oe_n, "R1 idle lines", {ser_clk, ser_out, ser_oe_n}, 7);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    host_rd(2'b00, rd); chk(rd == 8'h00, "R1 rx low", rd, 0);
    host_rd(2'b10, rd); chk(rd == 8'h00, "R1 status", rd, 0);

    for (int i = 0; i < NV; i++) begin
      logic [15:0] tx, rxv;
      bit en;
      tx = VEC[i][31:16]; rxv = VEC[i][15:0]; en = i[0];
      host_wr(2'b10, {7'b0, en});
      ser_in = rxv[15];
      host_wr(2'b01, tx[15:8]);
      host_wr(2'b00, tx[7:0]);
      run_xfer(rxv, 1'b0, got, rises, badper, tail, started);
      chk(started, "R4 start on select rise", started, 1);
      chk(rises == 16, "R6 rise count", rises, 16);
      chk(badper == 0, "R6 period", badper, 0);
      chk(got == tx, "R3 sent bits", got, tx);
      chk(tail == DIV, "R8 tail delay", tail, DIV);
      chk(irq == en, "R9 irq at end", irq, en);
      host_rd(2'b00, rd); chk(rd == rxv[7:0], "R7 rx low", rd, rxv[7:0]);
      host_rd(2'b01, rd); chk(rd == rxv[15:8], "R7 rx high", rd, rxv[15:8]);
      chk(irq == en, "R9 irq held until status read", irq, en);
      host_rd(2'b10, rd);
      chk(rd == {5'b0, en, 1'b0, en}, "R2 status", rd, {5'b0, en, 1'b0, en});
      chk(irq == 1'b0, "R9 irq cleared", irq, 0);
    end

    // R5: read with select low cancels the armed start
    @(negedge clk); hsel_n = 1'b0; hwr_n = 1'b0; haddr = 2'b00; hwdata = 8'h77;
    @(negedge clk); hwr_n = 1'b1; hrd_n = 1'b0; haddr = 2'b10;
    @(negedge clk); hrd_n = 1'b1; hsel_n = 1'b1;
    idle_check("R5 disarmed");

    // R4: select rise with no low-byte write
    host_wr(2'b01, 8'h99);
    idle_check("R4 no arm no start");

    // R10: writes and select edges while busy
    host_wr(2'b10, 8'h00);
    ser_in = 1'b0;
    host_wr(2'b01, 8'hC3);
    host_wr(2'b00, 8'hA5);
    run_xfer(16'h0000, 1'b1, got, rises, badper, tail, started);
    chk(got == 16'hC3A5, "R10 busy write ignored", got, 16'hC3A5);
    chk(rises == 16 && tail == DIV, "R10 no restart", rises, 16);
    host_wr(2'b01, 8'h11);
    idle_check("R10 busy write did not arm");

    // R2: unused address reads zero
    host_rd(2'b11, rd); chk(rd == 8'h00, "R2 unused address", rd, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule